// File: doc/BRIEF.md
# Symmetry axis voting and mirror extraction

This block turns per-row midpoint flags into a decision on where a vertical symmetry axis lies. Every accepted midpoint vector casts one vote at each column position whose flag is set. One vote counter per column collects the votes for a whole frame, and all the counters update together in the same cycle. A frame-start pulse empties the counters. A frame-end pulse compares every counter with a programmable threshold and registers the result as an axis flag vector. It also registers the lowest flagged column as an axis index, with a found bit.

Once an axis is registered, image rows can be streamed through the extraction path. For each column, the block pairs the pixel with its mirror across the registered axis. It keeps the pixel only when both are set, so a row comes out holding only its symmetric part. A mirror position that falls outside the image counts as an empty pixel.

Top module: `sym_axis_detector`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `axis_flags`, `axis_found`, `axis_idx`, `ext_valid` and `ext_pix` are all zero.
- R2: A cycle with `mid_valid` high and `frame_start` low adds one to the vote count of every column i where `mid_vec[i]` is 1.
- R3: A vote count stops at 255 and never wraps.
- R4: `frame_start` sets every vote count to zero. A `mid_vec` presented in the same cycle is ignored.
- R5: On `frame_end`, `axis_flags[i]` becomes 1 exactly when column i's count is strictly greater than `threshold`. The counts used are those before any vote cast in that same cycle.
- R6: `axis_flags`, `axis_found` and `axis_idx` change only in the cycle after `frame_end`, and hold their values otherwise. The vote counts persist, so a repeated `frame_end` re-evaluates them.
- R7: `axis_found` is the OR of `axis_flags`. `axis_idx` is the position of the lowest set flag, or 0 when none is set.
- R8: One cycle after `row_valid`, `ext_valid` is 1 and `ext_pix[i] = row_pix[i] & row_pix[2*a - i]`, where a is the registered `axis_idx`. A mirror position below 0 or above W-1 is taken as 0.
- R9: When `axis_found` is 0, every extracted row is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears all vote counts |
| frame_end | input | 1 | Evaluates counts against the threshold |
| mid_valid | input | 1 | Qualifies `mid_vec` |
| mid_vec | input | W | Midpoint flag per column |
| threshold | input | CNT_W | Vote count that must be exceeded |
| row_valid | input | 1 | Qualifies `row_pix` |
| row_pix | input | W | Image row to extract from |
| axis_flags | output | W | Registered axis decision per column |
| axis_found | output | 1 | At least one axis flagged |
| axis_idx | output | IDX_W | Lowest flagged column |
| ext_valid | output | 1 | Extracted row is valid |
| ext_pix | output | W | Symmetric part of the row |

## Verification
A vote counter that drops, doubles or wraps a vote stays hidden until the next frame end. It then shows up as a flag that is wrong against a threshold set right at the expected count. The saturation test runs 300 votes into one column, which would wrap an unguarded 8-bit counter to 44. A wrong registered axis shows up in the first extracted row, because kept pixels appear at mirror positions other than the expected ones. A flag register that drifts between frame ends is visible at once, since the monitor compares the flags in every cycle.

// File: rtl/sym_pkg.sv
package sym_pkg;
  // Mirror position of column col around axis ax, as a signed integer.
  function automatic int mirror_of(input int ax, input int col);
    return 2 * ax - col;
  endfunction
endpackage

// File: rtl/sym_vote_counter.sv
module sym_vote_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != CMAX)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sym_lowest_pick.sv
module sym_lowest_pick #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     flags,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (flags[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sym_mirror_and.sv
module sym_mirror_and #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     row,
  input  logic [IDX_W-1:0] axis,
  input  logic             en,
  output logic [W-1:0]     kept
);
  import sym_pkg::*;

  always_comb begin
    kept = '0;
    for (int i = 0; i < W; i++) begin
      int m;
      m = mirror_of(int'(axis), i);
      if (en && m >= 0 && m < W)
        kept[i] = row[i] & row[m];
    end
  end
endmodule

// File: rtl/sym_axis_detector.sv
module sym_axis_detector #(
  parameter int W     = 16,
  parameter int CNT_W = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             mid_valid,
  input  logic [W-1:0]     mid_vec,
  input  logic [CNT_W-1:0] threshold,
  input  logic             row_valid,
  input  logic [W-1:0]     row_pix,
  output logic [W-1:0]     axis_flags,
  output logic             axis_found,
  output logic [IDX_W-1:0] axis_idx,
  output logic             ext_valid,
  output logic [W-1:0]     ext_pix
);
  logic [CNT_W-1:0] votes [W];
  logic [W-1:0]     flags_nxt;
  logic             found_nxt;
  logic [IDX_W-1:0] idx_nxt;
  logic [W-1:0]     kept;

  for (genvar g = 0; g < W; g++) begin : g_col
    sym_vote_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (frame_start),
      .inc (mid_valid & mid_vec[g]),
      .cnt (votes[g])
    );
    assign flags_nxt[g] = votes[g] > threshold;
  end

  sym_lowest_pick #(.W(W), .IDX_W(IDX_W)) u_pick (
    .flags (flags_nxt),
    .any   (found_nxt),
    .idx   (idx_nxt)
  );

  sym_mirror_and #(.W(W), .IDX_W(IDX_W)) u_mirror (
    .row  (row_pix),
    .axis (axis_idx),
    .en   (axis_found),
    .kept (kept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      axis_flags <= '0;
      axis_found <= 1'b0;
      axis_idx   <= '0;
    end else if (frame_end) begin
      axis_flags <= flags_nxt;
      axis_found <= found_nxt;
      axis_idx   <= idx_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_valid <= 1'b0;
      ext_pix   <= '0;
    end else begin
      ext_valid <= row_valid;
      ext_pix   <= row_valid ? kept : '0;
    end
  end
endmodule

module sym_axis_detector_chk #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_end,
  input logic             row_valid,
  input logic [W-1:0]     row_pix,
  input logic [W-1:0]     axis_flags,
  input logic             axis_found,
  input logic [IDX_W-1:0] axis_idx,
  input logic             ext_valid,
  input logic [W-1:0]     ext_pix
);
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(axis_flags) && $stable(axis_idx)); // R6
  AST_FOUND_OR: assert property (@(posedge clk) disable iff (rst)
    axis_found == (|axis_flags)); // R7
  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (rst)
    axis_found |-> axis_flags[axis_idx] &&
      ((axis_flags & ((W'(1) << axis_idx) - W'(1))) == '0)); // R7
  AST_EXT_STROBE: assert property (@(posedge clk) disable iff (rst)
    row_valid |=> ext_valid); // R8
  AST_EXT_SUBSET: assert property (@(posedge clk) disable iff (rst)
    row_valid |=> (ext_pix & ~$past(row_pix)) == '0); // R8
  AST_NO_AXIS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    row_valid && !axis_found |=> ext_pix == '0); // R9
endmodule

bind sym_axis_detector sym_axis_detector_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_end  (frame_end),
  .row_valid  (row_valid),
  .row_pix    (row_pix),
  .axis_flags (axis_flags),
  .axis_found (axis_found),
  .axis_idx   (axis_idx),
  .ext_valid  (ext_valid),
  .ext_pix    (ext_pix)
);

// File: tb/sym_axis_detector_bench.sv
module sym_axis_detector_bench;
  localparam int W     = 16;
  localparam int CNT_W = 8;
  localparam int IDX_W = $clog2(W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 0, frame_end = 0, mid_valid = 0, row_valid = 0;
  logic [W-1:0] mid_vec = '0, row_pix = '0;
  logic [CNT_W-1:0] threshold = '0;
  logic [W-1:0] axis_flags, ext_pix;
  logic axis_found, ext_valid;
  logic [IDX_W-1:0] axis_idx;

  always #10 clk = ~clk;

  sym_axis_detector #(.W(W), .CNT_W(CNT_W)) u_sym_axis_detector (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
    .mid_valid(mid_valid), .mid_vec(mid_vec), .threshold(threshold),
    .row_valid(row_valid), .row_pix(row_pix), .axis_flags(axis_flags),
    .axis_found(axis_found), .axis_idx(axis_idx), .ext_valid(ext_valid),
    .ext_pix(ext_pix));

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  int m_cnt [W];
  logic [W-1:0] m_flags = '0;
  logic m_found = 0;
  int m_idx = 0;

  typedef struct { logic [W-1:0] flags; logic found; int idx; } axis_item_t;
  axis_item_t axq [$];
  logic [W-1:0] exq [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model updated with the same rules
  task automatic cycle(input bit fs, input bit fe, input bit mv,
                       input logic [W-1:0] mvec, input bit rv,
                       input logic [W-1:0] row);
    @(posedge clk); #2;
    frame_start = fs; frame_end = fe; mid_valid = mv; mid_vec = mvec;
    row_valid = rv; row_pix = row;
    if (rv) begin
      logic [W-1:0] e;
      e = '0;
      for (int i = 0; i < W; i++) begin
        int m;
        m = 2 * m_idx - i;
        if (m_found && m >= 0 && m < W) e[i] = row[i] & row[m];
      end
      exq.push_back(e);
    end
    if (fe) begin
      axis_item_t it;
      m_flags = '0;
      for (int i = 0; i < W; i++) m_flags[i] = (m_cnt[i] > int'(threshold));
      m_found = 0; m_idx = 0;
      for (int i = W - 1; i >= 0; i--) if (m_flags[i]) begin m_found = 1; m_idx = i; end
      it.flags = m_flags; it.found = m_found; it.idx = m_idx;
      axq.push_back(it);
    end
    if (fs) begin
      for (int i = 0; i < W; i++) m_cnt[i] = 0;
    end else if (mv) begin
      for (int i = 0; i < W; i++) if (mvec[i] && m_cnt[i] < 255) m_cnt[i]++;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle(0, 0, 0, '0, 0, '0);
  endtask

  task automatic votes(input int col, input int n);
    for (int k = 0; k < n; k++) cycle(0, 0, 1, W'(1) << col, 0, '0);
  endtask

  // monitor: compares outputs at falling edges against the scoreboard
  logic [W-1:0] hold_flags = '0;
  logic hold_found = 0;
  int hold_idx = 0;
  bit fe_pend = 0, rv_pend = 0;
  initial begin
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (fe_pend) begin
        axis_item_t it;
        it = axq.pop_front();
        hold_flags = it.flags; hold_found = it.found; hold_idx = it.idx;
        check(axis_found == hold_found, "R7", "axis_found", axis_found, hold_found);
        check(int'(axis_idx) == hold_idx, "R7", "axis_idx", axis_idx, hold_idx);
      end
      // R5 value on update, R6 hold between updates
      check(axis_flags == hold_flags, fe_pend ? "R5" : "R6", "axis_flags",
            axis_flags, hold_flags);
      check(ext_valid == rv_pend, "R8", "ext_valid", ext_valid, rv_pend);
      if (rv_pend) begin
        logic [W-1:0] e;
        e = exq.pop_front();
        check(ext_pix == e, hold_found ? "R8" : "R9", "ext_pix", ext_pix, e);
      end
      fe_pend = frame_end;
      rv_pend = row_valid;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < W; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs during reset
    check(axis_flags == '0 && !axis_found && axis_idx == '0, "R1", "axis during reset",
          axis_flags, 0);
    check(!ext_valid && ext_pix == '0, "R1", "ext during reset", ext_pix, 0);
    rst = 0;
    @(negedge clk);
    check(axis_flags == '0 && !axis_found && !ext_valid, "R1", "after reset", axis_flags, 0);

    // R9: no axis yet, extraction yields zero
    cycle(0, 0, 0, '0, 1, 16'hFFFF);

    // Frame A: R2 votes, R5 strict threshold
    threshold = 8'd2;
    cycle(1, 0, 0, '0, 0, '0);
    votes(5, 4);
    votes(2, 3);
    votes(9, 2);
    cycle(0, 0, 1, 16'h0224, 0, '0);           // R2: three columns in one vector
    cycle(0, 1, 1, 16'h0200, 0, '0);           // R5: vote in frame_end cycle excluded
    idle(1);
    cycle(0, 1, 0, '0, 0, '0);                 // R6: re-evaluation sees that vote
    idle(1);
    // R8: rows mirrored around the lowest axis
    cycle(0, 0, 0, '0, 1, 16'h041B);
    cycle(0, 0, 0, '0, 1, 16'h0011);
    cycle(0, 0, 0, '0, 1, 16'hFFFF);
    cycle(0, 0, 0, '0, 1, 16'h0001);
    idle(1);

    // Frame B: R4 vote ignored on frame_start, R3 saturation
    cycle(1, 0, 1, 16'h4000, 0, '0);
    votes(14, 300);
    threshold = 8'd254;
    cycle(0, 1, 0, '0, 0, '0);
    idle(1);
    cycle(0, 0, 0, '0, 1, 16'hB000);           // R8: mirror of col 12 out of range
    cycle(0, 0, 0, '0, 1, 16'hFFFF);
    threshold = 8'd255;
    cycle(0, 1, 0, '0, 0, '0);                 // R3: 255 is not above 255
    idle(1);
    cycle(0, 0, 0, '0, 1, 16'hFFFF);           // R9
    // R6: threshold and votes change without frame_end
    threshold = 8'd0;
    votes(3, 5);
    idle(2);
    // R4: clear, then a single vote over threshold 0
    cycle(1, 0, 0, '0, 0, '0);
    votes(0, 1);
    cycle(0, 1, 0, '0, 0, '0);
    idle(1);
    cycle(0, 0, 0, '0, 1, 16'h0003);
    idle(3);

    check(axq.size() == 0 && exq.size() == 0, "R8", "scoreboard drained",
          axq.size() + exq.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule